// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block drives the read strobe (`dior_n`) and the write strobe (`diow_n`) of a two-drive IDE channel during programmed I/O. Each drive has its own 16-bit timing word. The word packs the strobe-asserted (active) length, the strobe-negated (recovery) length and an IORDY-enable flag. Both counts are stored minus one and counted in clock periods of the channel clock, which is nominally 30 ns. The same word format also holds multiword DMA settings (for example 0x0707, 0x0201 and 0x0200), but this block only uses the PIO path.

A requester raises `req` for one cycle and gives `drive_sel` and `wr` with it. The controller works through four named states:
- `ST_IDLE` goes to `ST_ACTIVE` when it accepts a request, and latches the timing of the selected drive at that point.
- `ST_ACTIVE` goes to `ST_RECOVER` when the active count has run out and no IORDY hold applies.
- `ST_RECOVER` goes to `ST_FINISH` when the recovery count has run out.
- `ST_FINISH` pulses `done` and returns to `ST_IDLE` on the next cycle.

When the channel flag `wide_mode` is low, the programmed words are bypassed and a fixed slowest-mode timing is used instead. It is encoded as 0x050D.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: While reset is held and after it is released, `dior_n` and `diow_n` are high and `done` is low. Both drive words reset to 0x050D, which gives 6 active and 14 recovery clocks.
- R2: A timing word has three fields. Bits [11:8] hold the active clocks minus one, bits [5:0] hold the recovery clocks minus one, and bit 6 is the IORDY enable. A write with `cfg_we` high stores `cfg_word` into the word of drive `cfg_drive`.
- R3: A request with `wr`=0 asserts only `dior_n` (low) during the active phase. A request with `wr`=1 asserts only `diow_n`. The two strobes are never low together.
- R4: `done` is high for exactly one cycle, on the cycle after the last recovery clock. Both strobes are high in that cycle and in the cycle before it.
- R5: When `wide_mode` is 0, every access uses 6 active and 14 recovery clocks with IORDY disabled, whatever the programmed word holds.
- R6: When the IORDY enable bit is set and `iordy` is low, the active phase is held past its programmed count. The strobe then negates on the third rising clock edge after `iordy` goes high, because of the two-flop synchronizer.
- R7: When the IORDY enable bit is clear, the level of `iordy` has no effect on the strobe length.
- R8: `req` is acted on only in `ST_IDLE`. A request raised during `ST_ACTIVE` or `ST_RECOVER` is discarded, and no further strobe follows the current access.
- R9: `drive_sel` picks the timing word of that drive. Drive 0 and drive 1 keep independent words.
- R10: The count limits hold at both ends. Word 0x0000 gives 1 active and 1 recovery clock, and word 0x0F3F gives 16 active and 64 recovery clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a timing word |
| cfg_drive | input | 1 | Drive whose timing word is written |
| cfg_word | input | 16 | Timing word value |
| wide_mode | input | 1 | 1: use the programmed words; 0: use the fixed slowest timing |
| req | input | 1 | Access request, sampled in the idle state |
| drive_sel | input | 1 | Drive addressed by the request |
| wr | input | 1 | Direction of the request: 1 write, 0 read |
| iordy | input | 1 | Asynchronous ready from the drive |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle pulse when an access has fully recovered |

## Verification
The hardest state to reach is the IORDY hold. In that case the active count has already reached zero, but the controller must stay in the active state until a synchronized `iordy` is seen high. This has to be checked against an exact edge count through the two synchronizer flops. The stimulus keeps `iordy` low across a short programmed active phase. It raises `iordy` right after a chosen strobe-asserted sample, so the expected stretched length is known to the clock. A second access of the same kind is then run with IORDY disabled to show that the level is ignored. A request pulsed in the middle of a strobe checks that late requests are discarded.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

    localparam int WORD_W  = 16;
    localparam int ACT_LSB = 8;
    localparam int ACT_W   = 4;
    localparam int REC_LSB = 0;
    localparam int REC_W   = 6;
    localparam int RDY_BIT = 6;
    localparam int CNT_W   = (ACT_W > REC_W) ? ACT_W : REC_W;

    localparam logic [WORD_W-1:0] USED_MASK =
        WORD_W'(((1 << ACT_W) - 1) << ACT_LSB) |
        WORD_W'(((1 << REC_W) - 1) << REC_LSB) |
        WORD_W'(1 << RDY_BIT);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_RECOVER,
        ST_FINISH
    } pio_state_e;

    typedef struct packed {
        logic             rdy_en;
        logic [ACT_W-1:0] act_m1;
        logic [REC_W-1:0] rec_m1;
    } pio_timing_t;

endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            q      <= RESET_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pio_timing_bank.sv
module pio_timing_bank
    import pio_strobe_pkg::*;
#(
    parameter int                NUM_DRIVES = 2,
    parameter int                DRV_W      = 1,
    parameter logic [WORD_W-1:0] SLOW_WORD  = 16'h050D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DRV_W-1:0]  wsel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [DRV_W-1:0]  rsel,
    input  logic              wide_mode,
    output pio_timing_t       timing
);
    logic [WORD_W-1:0] words [NUM_DRIVES];
    logic [WORD_W-1:0] picked;
    logic [WORD_W-1:0] chosen;
    logic              unused_spare;

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[d] <= SLOW_WORD;
            end else if (we && (wsel == DRV_W'(d))) begin
                words[d] <= wdata;
            end
        end
    end

    always_comb begin
        picked = SLOW_WORD;
        for (int d = 0; d < NUM_DRIVES; d++) begin
            if (rsel == DRV_W'(d)) begin
                picked = words[d];
            end
        end
    end

    assign chosen        = wide_mode ? picked : SLOW_WORD;
    assign timing.rdy_en = chosen[RDY_BIT] & wide_mode;
    assign timing.act_m1 = chosen[ACT_LSB +: ACT_W];
    assign timing.rec_m1 = chosen[REC_LSB +: REC_W];
    assign unused_spare  = ^(chosen & ~USED_MASK);
endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import pio_strobe_pkg::*;
#(
    parameter int                NUM_DRIVES = 2,
    parameter logic [WORD_W-1:0] SLOW_WORD  = 16'h050D,
    localparam int               DRV_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DRV_W-1:0]  cfg_drive,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              wide_mode,
    input  logic              req,
    input  logic [DRV_W-1:0]  drive_sel,
    input  logic              wr,
    input  logic              iordy,
    output logic              dior_n,
    output logic              diow_n,
    output logic              done
);
    pio_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q, wr_d;
    logic             rdy_en_q, rdy_en_d;
    logic [REC_W-1:0] rec_q, rec_d;
    pio_timing_t      sel_tim;
    logic             rdy_s;

    pio_timing_bank #(
        .NUM_DRIVES (NUM_DRIVES),
        .DRV_W      (DRV_W),
        .SLOW_WORD  (SLOW_WORD)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wsel      (cfg_drive),
        .wdata     (cfg_word),
        .rsel      (drive_sel),
        .wide_mode (wide_mode),
        .timing    (sel_tim)
    );

    pio_sync2 #(.RESET_VAL(1'b1)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (iordy),
        .q     (rdy_s)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            wr_q     <= 1'b0;
            rdy_en_q <= 1'b0;
            rec_q    <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            wr_q     <= wr_d;
            rdy_en_q <= rdy_en_d;
            rec_q    <= rec_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wr_d     = wr_q;
        rdy_en_d = rdy_en_q;
        rec_d    = rec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d  = ST_ACTIVE;
                    cnt_d    = CNT_W'(sel_tim.act_m1);
                    wr_d     = wr;
                    rdy_en_d = sel_tim.rdy_en;
                    rec_d    = sel_tim.rec_m1;
                end
            end
            ST_ACTIVE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (!(rdy_en_q && !rdy_s)) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(rec_q);
                end
            end
            ST_RECOVER: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        dior_n = 1'b1;
        diow_n = 1'b1;
        done   = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                dior_n = wr_q;
                diow_n = !wr_q;
            end
            ST_FINISH:  done = 1'b1;
            ST_IDLE, ST_RECOVER: ;
        endcase
    end
endmodule

// File: rtl/pio_strobe_checker.sv
module pio_strobe_checker (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic dior_n,
    input logic diow_n,
    input logic done
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dior_n && diow_n && $past(dior_n) && $past(diow_n))); // R4

    AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dior_n) || $fell(diow_n)) |-> $past(req)); // R8

    AST_NO_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n) |=> diow_n); // R3
endmodule

bind ide_pio_strobe_gen pio_strobe_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .dior_n (dior_n),
    .diow_n (diow_n),
    .done   (done)
);

// File: tb/sim_ide_pio_strobe_gen.sv
module sim_ide_pio_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_drive = '0;
    logic [15:0] cfg_word = '0;
    logic        wide_mode = 1'b1;
    logic        req = 1'b0;
    logic [0:0]  drive_sel = '0;
    logic        wr = 1'b0;
    logic        iordy = 1'b1;
    logic        dior_n, diow_n, done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ide_pio_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_drive(cfg_drive),
        .cfg_word(cfg_word), .wide_mode(wide_mode), .req(req),
        .drive_sel(drive_sel), .wr(wr), .iordy(iordy),
        .dior_n(dior_n), .diow_n(diow_n), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_word(input int drv, input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_drive = 1'(drv); cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; rise_at / extra_at: active-sample index after which iordy
    // rises / a late req pulse is raised (0 = never).
    task automatic xfer(input int drv, input bit w, input int ea, input int er,
                        input int rise_at, input int extra_at, input string tag);
        int act = 0, rec = 0, wrong = 0;
        @(negedge clk);
        drive_sel = 1'(drv); wr = w; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (((w ? diow_n : dior_n) == 1'b0) && act < 300) begin
            act++;
            if ((w ? dior_n : diow_n) == 1'b0) wrong++;
            if (act == rise_at) iordy = 1'b1;
            req = (act == extra_at);
            @(negedge clk);
        end
        req = 1'b0;
        while (!done && rec < 300) begin
            rec++;
            if (!dior_n || !diow_n) wrong++;
            @(negedge clk);
        end
        chk(act == ea, tag, "active clocks", act, ea);
        chk(rec == er, tag, "recovery clocks", rec, er);
        chk(wrong == 0, "R3", "wrong strobe samples", wrong, 0);
        chk(done == 1'b1, "R4", "done after recovery", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && dior_n && diow_n, "R4", "done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        chk(dior_n && diow_n && !done, "R1", "outputs in reset",
            int'({dior_n, diow_n, done}), 6);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(dior_n && diow_n && !done, "R1", "outputs after reset",
            int'({dior_n, diow_n, done}), 6);
        xfer(0, 1'b0, 6, 14, 0, 0, "R1");
        xfer(1, 1'b1, 6, 14, 0, 0, "R1");
    endtask

    task automatic t_programmed;
        set_word(0, 16'h0200);
        set_word(1, 16'h0707);
        xfer(0, 1'b0, 3, 1, 0, 0, "R2");
        xfer(1, 1'b1, 8, 8, 0, 0, "R9");
        xfer(0, 1'b1, 3, 1, 0, 0, "R3");
        xfer(1, 1'b0, 8, 8, 0, 0, "R9");
    endtask

    task automatic t_extremes;
        set_word(0, 16'h0000);
        set_word(1, 16'h0F3F);
        xfer(0, 1'b0, 1, 1, 0, 0, "R10");
        xfer(1, 1'b1, 16, 64, 0, 0, "R10");
    endtask

    task automatic t_iordy;
        set_word(0, 16'h0241);
        iordy = 1'b0;
        xfer(0, 1'b0, 12, 2, 10, 0, "R6");
        iordy = 1'b1;
        xfer(0, 1'b1, 3, 2, 0, 0, "R6");
    endtask

    task automatic t_iordy_off;
        set_word(1, 16'h0302);
        iordy = 1'b0;
        xfer(1, 1'b0, 4, 3, 0, 0, "R7");
        iordy = 1'b1;
    endtask

    task automatic t_narrow;
        wide_mode = 1'b0;
        xfer(1, 1'b1, 6, 14, 0, 0, "R5");
        iordy = 1'b0;
        xfer(0, 1'b0, 6, 14, 0, 0, "R5");
        iordy = 1'b1;
        wide_mode = 1'b1;
    endtask

    task automatic t_busy_req;
        int extra = 0;
        set_word(0, 16'h0707);
        xfer(0, 1'b0, 8, 8, 0, 3, "R8");
        repeat (12) begin
            if (!dior_n || !diow_n || done) extra++;
            @(negedge clk);
        end
        chk(extra == 0, "R8", "activity after late req", extra, 0);
    endtask

    initial begin
        t_reset();
        t_programmed();
        t_extremes();
        t_iordy();
        t_iordy_off();
        t_narrow();
        t_busy_req();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule